// File: doc/BRIEF.md
# Bank Clock Phase Skew Generator

This block produces the clock of one output bank from a base clock. The base clock arrives as a level on `base_in`, sampled on a fast tick clock; the tick grid is the finest time resolution the block can place an edge on. A pair of three-level select inputs picks how the bank clock relates to the base clock. It can be a copy shifted by a signed whole number of time units. On the divider bank types it can also be a divide-by-2 copy, a divide-by-4 copy or an inverted copy. A three-level range input sets how long one time unit is, in ticks.

The base period is the parameter `PERIOD_TICKS`. One time unit is `PERIOD_TICKS / MF`, where the range input selects MF. A lagging shift is a plain delay of the base stream. A leading shift is a delay of one period less its magnitude, because the base clock repeats. The parameter `BANK_KIND` selects the bank type: 0 is a single-step bank, 1 is a double-step bank with /2 and /4, and 2 is a double-step bank with /2 and invert. The select inputs and the range input are sampled only at a base rising edge.

Top module: `bank_skew_gen`

## Requirements
- R1: While `rst_n` is low, `bank_out` is 0. Reset leaves zero skew active and the range at Mid.
- R2: Each select input is three-level: 2'b00 is L, 2'b01 is M and 2'b10 is H. The range input uses the same coding and selects MF: L gives 32, M gives 16 and H gives 8. One time unit is `PERIOD_TICKS/MF` ticks.
- R3: The code index is 3×level(`code_msd`) + level(`code_lsd`), with L=0, M=1 and H=2. On a single-step bank (`BANK_KIND`=0) the skew is index−4 time units, so LL gives −4 and HH gives +4.
- R4: On a double-step bank (`BANK_KIND` 1 or 2), indices 1 to 7 give a skew of 2×(index−4) units, from −6 to +6.
- R5: A skew of s≥0 units delays the zero-skew output by s×unit ticks. A skew of s<0 delays it by `PERIOD_TICKS`+s×unit ticks.
- R6: At zero skew, `bank_out` equals `base_in` as sampled two ticks earlier.
- R7: When `BANK_KIND`=1, code LL (index 0) selects divide-by-2 and code HH (index 8) selects divide-by-4.
- R8: When `BANK_KIND`=2, code LL selects divide-by-2 and code HH selects the inverse of the zero-skew output.
- R9: New select or range values take effect only at a base rising edge. The first tick that uses them is the one whose zero-skew output shows that rising edge.
- R10: Divided outputs count base rising edges from reset. After the nth rise, the /2 output is 1 when n is odd. The /4 output is 1 when n mod 4 is 1 or 2. Both outputs are 0 before the first rise, and both rise together with the zero-skew output.
- R11: The unused select value 2'b11 acts as M on every select and on the range input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; one period is one grid step |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_in | input | 1 | Base clock level, sampled on every tick |
| range_sel | input | 2 | Three-level range select (sets MF) |
| code_msd | input | 2 | First digit of the bank select code |
| code_lsd | input | 2 | Second digit of the bank select code |
| bank_out | output | 1 | Registered bank clock |

## Verification
The bench does not wait for a settle time and then check. It computes the expected level of `bank_out` on every tick. That value is the base level sampled two ticks earlier plus the selected delay, or the divider or inverse value. The bench latches its own copy of the select code one tick after each sampled base rise, which is the same tick at which the design switches. Comparison happens on the falling clock edge after each rising edge, so every tick across a code change, a divider phase and a range change is checked against this timing, including the tick at which the switch happens. Three instances, one of each bank type, receive the same stimulus.

// File: rtl/skew_pkg.sv
package skew_pkg;

  typedef enum logic [1:0] {
    OUT_SKEW = 2'd0,
    OUT_DIV2 = 2'd1,
    OUT_DIV4 = 2'd2,
    OUT_INV  = 2'd3
  } out_mode_e;

  // Three-level select: 00 low, 10 high, anything else mid.
  function automatic int tri_level(input logic [1:0] v);
    case (v)
      2'b00:   return 0;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int code_index(input logic [1:0] msd, input logic [1:0] lsd);
    return 3 * tri_level(msd) + tri_level(lsd);
  endfunction

endpackage

// File: rtl/skew_decode.sv
module skew_decode
  import skew_pkg::*;
#(
  parameter int PERIOD = 64,
  parameter int KIND   = 0,
  localparam int DW    = $clog2(PERIOD)
) (
  input  logic [1:0]    code_msd,
  input  logic [1:0]    code_lsd,
  input  logic [1:0]    range_sel,
  output out_mode_e     mode,
  output logic [DW-1:0] delay
);

  localparam int UNIT_LO  = PERIOD / 32;
  localparam int UNIT_MID = PERIOD / 16;
  localparam int UNIT_HI  = PERIOD / 8;

  always_comb begin
    int idx;
    int steps;
    int unit;
    int dly_i;
    idx = code_index(code_msd, code_lsd);
    case (tri_level(range_sel))
      0:       unit = UNIT_LO;
      2:       unit = UNIT_HI;
      default: unit = UNIT_MID;
    endcase
    mode = OUT_SKEW;
    if (KIND == 0) begin
      steps = idx - 4;
    end else begin
      steps = 2 * (idx - 4);
      if (idx == 0) mode = OUT_DIV2;
      if (idx == 8) mode = (KIND == 1) ? OUT_DIV4 : OUT_INV;
    end
    if (steps >= 0) dly_i = steps * unit;
    else            dly_i = PERIOD + steps * unit;
    if (mode != OUT_SKEW) dly_i = 0;
    delay = DW'(dly_i);
  end

endmodule

// File: rtl/skew_tap_line.sv
module skew_tap_line #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [AW-1:0] tap,
  output logic          head,
  output logic          prev,
  output logic          dout
);

  logic [DEPTH-1:0] line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line[0] <= 1'b0;
    else        line[0] <= din;
  end

  for (genvar gi = 1; gi < DEPTH; gi++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line[gi] <= 1'b0;
      else        line[gi] <= line[gi-1];
    end
  end

  assign head = line[0];
  assign prev = line[1];
  assign dout = line[tap];

endmodule

// File: rtl/skew_div_seq.sv
module skew_div_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic div2_nxt,
  output logic div4_nxt
);

  logic [1:0] cnt;
  logic [1:0] cnt_n;

  assign cnt_n    = rise ? cnt + 2'd1 : cnt;
  assign div2_nxt = ~cnt_n[0];
  assign div4_nxt = ~cnt_n[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 2'd3;
    else        cnt <= cnt_n;
  end

  AST_DIV_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(rise)); // R10
  AST_DIV4_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt[1]) |-> (cnt[0] == 1'b0)); // R10

endmodule

// File: rtl/bank_skew_gen.sv
module bank_skew_gen
  import skew_pkg::*;
#(
  parameter int PERIOD_TICKS = 64,
  parameter int BANK_KIND    = 0,
  localparam int DW          = $clog2(PERIOD_TICKS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_in,
  input  logic [1:0] range_sel,
  input  logic [1:0] code_msd,
  input  logic [1:0] code_lsd,
  output logic       bank_out
);

  logic          head, prev, tapped, rise;
  logic [1:0]    act_msd, act_lsd, act_rng;
  logic [1:0]    nxt_msd, nxt_lsd, nxt_rng;
  out_mode_e     mode_n, mode_q;
  logic [DW-1:0] dly_n, dly_q;
  logic          div2_nxt, div4_nxt;
  logic          out_nxt;
  logic [1:0]    warm;

  skew_tap_line #(.DEPTH(PERIOD_TICKS)) u_line (
    .clk(clk), .rst_n(rst_n), .din(base_in), .tap(dly_n),
    .head(head), .prev(prev), .dout(tapped)
  );

  assign rise = head & ~prev;

  // Settings are latched only at a base rising edge.
  assign nxt_msd = rise ? code_msd  : act_msd;
  assign nxt_lsd = rise ? code_lsd  : act_lsd;
  assign nxt_rng = rise ? range_sel : act_rng;

  skew_decode #(.PERIOD(PERIOD_TICKS), .KIND(BANK_KIND)) u_dec (
    .code_msd(nxt_msd), .code_lsd(nxt_lsd), .range_sel(nxt_rng),
    .mode(mode_n), .delay(dly_n)
  );

  if (BANK_KIND != 0) begin : g_div
    skew_div_seq u_div (
      .clk(clk), .rst_n(rst_n), .rise(rise),
      .div2_nxt(div2_nxt), .div4_nxt(div4_nxt)
    );
  end else begin : g_nodiv
    assign div2_nxt = 1'b0;
    assign div4_nxt = 1'b0;
  end

  always_comb begin
    case (mode_n)
      OUT_DIV2: out_nxt = div2_nxt;
      OUT_DIV4: out_nxt = div4_nxt;
      OUT_INV:  out_nxt = ~head;
      default:  out_nxt = tapped;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_msd  <= 2'b01;
      act_lsd  <= 2'b01;
      act_rng  <= 2'b01;
      mode_q   <= OUT_SKEW;
      dly_q    <= '0;
      bank_out <= 1'b0;
      warm     <= 2'd0;
    end else begin
      act_msd  <= nxt_msd;
      act_lsd  <= nxt_lsd;
      act_rng  <= nxt_rng;
      mode_q   <= mode_n;
      dly_q    <= dly_n;
      bank_out <= out_nxt;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd0) |-> !bank_out); // R1
  AST_ZERO_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && mode_q == OUT_SKEW && dly_q == '0) |-> (bank_out == $past(base_in, 2))); // R6
  AST_INV_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && mode_q == OUT_INV) |-> (bank_out == !$past(base_in, 2))); // R8
  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && !$past(rise)) |-> $stable({act_msd, act_lsd, act_rng})); // R9

endmodule

// File: tb/sim_bank_skew_gen.sv
module sim_bank_skew_gen;

  localparam int P   = 64;
  localparam int OFF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_in = 1'b0;
  logic [1:0] c_rng = 2'b01, c_msd = 2'b01, c_lsd = 2'b01;
  logic o0, o3, o4;

  int k = 0;
  int checks = 0;
  int fails = 0;
  int nr = 0;
  logic [1:0] rm = 2'b01, rl = 2'b01, rr = 2'b01;

  always #4 clk = ~clk;

  bank_skew_gen #(.PERIOD_TICKS(P), .BANK_KIND(0)) u0 (
    .clk(clk), .rst_n(rst_n), .base_in(base_in), .range_sel(c_rng),
    .code_msd(c_msd), .code_lsd(c_lsd), .bank_out(o0));
  bank_skew_gen #(.PERIOD_TICKS(P), .BANK_KIND(1)) u3 (
    .clk(clk), .rst_n(rst_n), .base_in(base_in), .range_sel(c_rng),
    .code_msd(c_msd), .code_lsd(c_lsd), .bank_out(o3));
  bank_skew_gen #(.PERIOD_TICKS(P), .BANK_KIND(2)) u4 (
    .clk(clk), .rst_n(rst_n), .base_in(base_in), .range_sel(c_rng),
    .code_msd(c_msd), .code_lsd(c_lsd), .bank_out(o4));

  function automatic bit vfun(int t);
    if (t < OFF) return 1'b0;
    return ((t - OFF) % P) < (P / 2);
  endfunction

  function automatic int lvl(logic [1:0] v);
    if (v == 2'b00) return 0;
    if (v == 2'b10) return 2;
    return 1; // R11: 2'b11 acts as mid
  endfunction

  // Expected output after edge m, built from R2..R10.
  function automatic bit expv(int kind, int m);
    int idx, u, s, d;
    idx = 3 * lvl(rm) + lvl(rl);
    u = (lvl(rr) == 0) ? P / 32 : (lvl(rr) == 2) ? P / 8 : P / 16;
    if (kind == 0) s = idx - 4;
    else begin
      if (idx == 0) return (nr % 2) == 1;
      if (idx == 8 && kind == 1) return ((nr % 4) == 1) || ((nr % 4) == 2);
      if (idx == 8) return !vfun(m - 1);
      s = 2 * (idx - 4);
    end
    d = (s >= 0) ? s * u : P + s * u;
    return vfun(m - 1 - d);
  endfunction

  // Base stimulus and reference latch of settings (R9, R10).
  initial begin
    forever begin
      @(posedge clk);
      k++;
      if (!rst_n) begin
        rm = 2'b01; rl = 2'b01; rr = 2'b01; nr = 0;
      end else if (vfun(k - 1) && !vfun(k - 2)) begin
        rm = c_msd; rl = c_lsd; rr = c_rng; nr++;
      end
      #1 base_in = vfun(k + 1);
    end
  end

  task automatic watch(int n, string tag);
    int errs[3];
    bit fa[3], fe[3];
    bit got, ex;
    for (int b = 0; b < 3; b++) errs[b] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int b = 0; b < 3; b++) begin
        got = (b == 0) ? o0 : (b == 1) ? o3 : o4;
        ex = expv(b, k);
        if (got !== ex) begin
          if (errs[b] == 0) begin fa[b] = got; fe[b] = ex; end
          errs[b]++;
        end
      end
    end
    for (int b = 0; b < 3; b++) begin
      checks++;
      if (errs[b] != 0) begin
        fails++;
        $display("FAIL %s kind %0d: actual %0b expected %0b (%0d ticks wrong)",
                 tag, b, fa[b], fe[b], errs[b]);
      end
    end
  endtask

  task automatic set_code(logic [1:0] m, logic [1:0] l, logic [1:0] r);
    @(negedge clk);
    c_msd = m; c_lsd = l; c_rng = r;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 5; i++) @(negedge clk);
    checks++;
    if ({o0, o3, o4} !== 3'b000) begin
      fails++;
      $display("FAIL R1 reset: actual %b expected 000", {o0, o3, o4});
    end
    rst_n = 1'b1;
    watch(3 * P, "R1 R6 R10 after reset");
  endtask

  task automatic t_zero;
    set_code(2'b01, 2'b01, 2'b01);
    watch(2 * P, "R6 zero skew");
  endtask

  task automatic t_range;
    set_code(2'b01, 2'b10, 2'b00); watch(2 * P, "R2 range low");
    set_code(2'b01, 2'b10, 2'b01); watch(2 * P, "R2 range mid");
    set_code(2'b01, 2'b10, 2'b10); watch(2 * P, "R2 range high");
    set_code(2'b01, 2'b10, 2'b11); watch(2 * P, "R11 range code 11");
  endtask

  task automatic t_sweep_single;
    for (int i = 0; i < 9; i++) begin
      set_code(2'(i / 3 == 2 ? 2 : i / 3), 2'(i % 3 == 2 ? 2 : i % 3), 2'b10);
      watch(2 * P, "R3 R5 code sweep");
    end
  endtask

  task automatic t_sweep_double;
    for (int i = 1; i < 8; i++) begin
      set_code(2'(i / 3 == 2 ? 2 : i / 3), 2'(i % 3 == 2 ? 2 : i % 3), 2'b00);
      watch(2 * P, "R4 R5 double step");
    end
  endtask

  task automatic t_div;
    set_code(2'b00, 2'b00, 2'b01); watch(5 * P, "R7 R8 R10 code LL");
    set_code(2'b10, 2'b10, 2'b01); watch(5 * P, "R7 R8 code HH");
  endtask

  task automatic t_midchange;
    set_code(2'b01, 2'b01, 2'b01);
    watch(P, "R9 setup");
    while (((k - OFF) % P) != 10) @(negedge clk);
    c_msd = 2'b10; c_lsd = 2'b00; c_rng = 2'b10;
    watch(2 * P, "R9 change mid period");
  endtask

  task automatic t_illegal;
    set_code(2'b11, 2'b11, 2'b01); watch(2 * P, "R11 code 11 11");
    set_code(2'b11, 2'b10, 2'b00); watch(2 * P, "R11 code 11 H");
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_range();
    t_sweep_single();
    t_sweep_double();
    t_div();
    t_midchange();
    t_illegal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule